// File: doc/BRIEF.md
# Transmit/Receive Word FIFO Pair with Wrapping Level Count

This block holds the two word queues that sit between a serial bus engine and the register interface of a serial controller. The transmit queue is filled by register writes and drained by the bus engine. The receive queue is filled by the bus engine and drained by register reads. Each queue stores eight 9-bit words in first-in, first-out order.

Each queue reports its fill level in a 3-bit field, so the field counts from 0 to 7. When all eight entries are occupied, the field wraps to 0. Software can therefore tell a full queue from an empty one only by looking at the separate full flags in the status word. The status word also carries half-full flags and a sticky busy-error bit. That bit records whether a soft reset was issued while received words were still waiting to be read.

Enable and soft-reset controls arrive as single-bit inputs from the controller's control register. Their register positions are bit 11 for transmit enable, bit 12 for receive enable and bit 7 for soft reset.

Top module: `sfifo_pair`

## Requirements
- R1: Each queue stores up to 8 words of 9 bits and returns them in the order they were written.
- R2: Each level output equals the occupancy modulo 8, so it reads 0 when the queue holds 8 words.
- R3: Status bit 13 is 1 exactly when the transmit queue holds 8 words. Status bit 0 is 1 exactly when the receive queue holds 8 words.
- R4: Status bit 12 (transmit) and status bit 14 (receive) are 1 exactly when the queue holds at least 4 words.
- R5: A push to a full queue is ignored. If a pop is made in the same cycle, the pop still takes effect and the level drops by one.
- R6: A pop from an empty queue leaves the level unchanged and leaves the read-data output at its last value.
- R7: While a queue's enable input is 0, pushes and pops to that queue are ignored and its stored words are kept.
- R8: In a cycle with soft reset high, both queues become empty at the next clock edge, and pushes made in that cycle are discarded.
- R9: Status bit 9 (busy error) is updated only in the first cycle of a soft-reset pulse. It is set if the receive queue then holds data and cleared if it is empty; otherwise it holds its value.
- R10: A popped word appears on the read-data output after the clock edge that accepts the pop, and stays there until the next accepted pop.
- R11: After the synchronous reset, both queues are empty, the status word is 0 and both read-data outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | Transmit queue enable |
| rx_en_i | input | 1 | Receive queue enable |
| srst_i | input | 1 | Soft reset of both queues |
| tx_push_i | input | 1 | Register-side write into transmit queue |
| tx_wdata_i | input | 9 | Word to write into transmit queue |
| tx_pop_i | input | 1 | Bus-engine read from transmit queue |
| tx_rdata_o | output | 9 | Last word taken from transmit queue |
| rx_push_i | input | 1 | Bus-engine write into receive queue |
| rx_wdata_i | input | 9 | Word to write into receive queue |
| rx_pop_i | input | 1 | Register-side read from receive queue |
| rx_rdata_o | output | 9 | Last word taken from receive queue |
| tx_lvl_o | output | 3 | Transmit level, occupancy modulo 8 |
| rx_lvl_o | output | 3 | Receive level, occupancy modulo 8 |
| sta_o | output | 16 | Status: bit 0 rx full, 9 busy error, 12 tx half, 13 tx full, 14 rx half |

## Verification
The bench fills each queue to eight words and checks the point where the level field wraps to 0. A design that widened or saturated the count would show 7 or 8 there, and one that dropped the full flag would look empty. It pushes a ninth word and then drains the queue; an overwrite on full would return a stale or out-of-order word. It pops past empty; a design that moved its pointers would show wrapped levels or new data. It also issues soft resets with and without waiting receive data. A design that latched the busy error on every cycle of the pulse, or that ignored the receive state, would report the wrong bit 9.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

    localparam int WORD_W = 9;
    localparam int DEPTH  = 8;
    localparam int STA_W  = 16;

    localparam int STA_RXFULL  = 0;
    localparam int STA_BUSYERR = 9;
    localparam int STA_TXHALF  = 12;
    localparam int STA_TXFULL  = 13;
    localparam int STA_RXHALF  = 14;

    typedef struct packed {
        logic full;
        logic half;
        logic empty;
    } occ_t;

    typedef struct packed {
        logic srst;
        logic tx_en;
        logic rx_en;
    } ctl_t;

    function automatic ctl_t pack_ctl(input logic srst, input logic tx_en, input logic rx_en);
        ctl_t c;
        c.srst  = srst;
        c.tx_en = tx_en;
        c.rx_en = rx_en;
        return c;
    endfunction

endpackage

// File: rtl/sfifo_core.sv
module sfifo_core #(
    parameter int W = 9,
    parameter int D = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    push,
    input  logic [W-1:0]            wdata,
    input  logic                    pop,
    output logic [W-1:0]            rdata,
    output logic [$clog2(D)-1:0]    lvl,
    output sfifo_pkg::occ_t         occ
);
    localparam int AW = $clog2(D);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] FULL_CNT = CW'(D);
    localparam logic [CW-1:0] HALF_CNT = CW'(D / 2);

    logic [W-1:0]  mem [D];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(D - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = en && push && (cnt != FULL_CNT) && !clr;
    assign do_pop  = en && pop  && (cnt != '0) && !clr;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata <= '0;
        else if (do_pop) rdata <= mem[rd_ptr];
    end

    assign lvl       = cnt[AW-1:0];
    assign occ.full  = (cnt == FULL_CNT);
    assign occ.half  = (cnt >= HALF_CNT);
    assign occ.empty = (cnt == '0);

endmodule

// File: rtl/sfifo_ctl.sv
module sfifo_ctl (
    input  logic              clk,
    input  logic              rst,
    input  sfifo_pkg::ctl_t   ctl,
    input  logic              rx_empty,
    output logic              clr,
    output logic              busy_err
);
    logic srst_q;

    assign clr = ctl.srst;

    always_ff @(posedge clk) begin
        if (rst) begin
            srst_q   <= 1'b0;
            busy_err <= 1'b0;
        end else begin
            srst_q <= ctl.srst;
            if (ctl.srst && !srst_q) busy_err <= !rx_empty;
        end
    end

endmodule

// File: rtl/sfifo_sta.sv
module sfifo_sta #(
    parameter int SW = 16
) (
    input  sfifo_pkg::occ_t tx_occ,
    input  sfifo_pkg::occ_t rx_occ,
    input  logic            busy_err,
    output logic [SW-1:0]   sta
);
    import sfifo_pkg::*;

    always_comb begin
        sta              = '0;
        sta[STA_RXFULL]  = rx_occ.full;
        sta[STA_BUSYERR] = busy_err;
        sta[STA_TXHALF]  = tx_occ.half;
        sta[STA_TXFULL]  = tx_occ.full;
        sta[STA_RXHALF]  = rx_occ.half;
    end

endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair #(
    parameter int W  = sfifo_pkg::WORD_W,
    parameter int D  = sfifo_pkg::DEPTH,
    parameter int SW = sfifo_pkg::STA_W,
    localparam int AW = $clog2(D)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_en_i,
    input  logic          rx_en_i,
    input  logic          srst_i,
    input  logic          tx_push_i,
    input  logic [W-1:0]  tx_wdata_i,
    input  logic          tx_pop_i,
    output logic [W-1:0]  tx_rdata_o,
    input  logic          rx_push_i,
    input  logic [W-1:0]  rx_wdata_i,
    input  logic          rx_pop_i,
    output logic [W-1:0]  rx_rdata_o,
    output logic [AW-1:0] tx_lvl_o,
    output logic [AW-1:0] rx_lvl_o,
    output logic [SW-1:0] sta_o
);
    import sfifo_pkg::*;

    ctl_t ctl;
    occ_t tx_occ, rx_occ;
    logic clr, busy_err;

    assign ctl = pack_ctl(srst_i, tx_en_i, rx_en_i);

    sfifo_ctl u_ctl (
        .clk(clk), .rst(rst), .ctl(ctl), .rx_empty(rx_occ.empty),
        .clr(clr), .busy_err(busy_err)
    );

    sfifo_core #(.W(W), .D(D)) u_tx (
        .clk(clk), .rst(rst), .clr(clr), .en(ctl.tx_en),
        .push(tx_push_i), .wdata(tx_wdata_i), .pop(tx_pop_i),
        .rdata(tx_rdata_o), .lvl(tx_lvl_o), .occ(tx_occ)
    );

    sfifo_core #(.W(W), .D(D)) u_rx (
        .clk(clk), .rst(rst), .clr(clr), .en(ctl.rx_en),
        .push(rx_push_i), .wdata(rx_wdata_i), .pop(rx_pop_i),
        .rdata(rx_rdata_o), .lvl(rx_lvl_o), .occ(rx_occ)
    );

    sfifo_sta #(.SW(SW)) u_sta (
        .tx_occ(tx_occ), .rx_occ(rx_occ), .busy_err(busy_err), .sta(sta_o)
    );

endmodule

// File: rtl/sfifo_pair_chk.sv
module sfifo_pair_chk (
    input logic        clk,
    input logic        rst,
    input logic        tx_en_i,
    input logic        rx_en_i,
    input logic        srst_i,
    input logic        tx_push_i,
    input logic        tx_pop_i,
    input logic        rx_push_i,
    input logic        rx_pop_i,
    input logic [8:0]  tx_rdata_o,
    input logic [8:0]  rx_rdata_o,
    input logic [2:0]  tx_lvl_o,
    input logic [2:0]  rx_lvl_o,
    input logic [15:0] sta_o
);
    logic rx_empty;
    assign rx_empty = (rx_lvl_o == 3'd0) && !sta_o[0];

    assert_full_wraps_R2: assert property (@(posedge clk) disable iff (rst)
        sta_o[13] |-> (tx_lvl_o == 3'd0));

    assert_full_implies_half_R4: assert property (@(posedge clk) disable iff (rst)
        sta_o[0] |-> sta_o[14]);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (sta_o[13] && tx_en_i && tx_push_i && !tx_pop_i && !srst_i)
        |=> (sta_o[13] && $stable(tx_lvl_o)));

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_empty && rx_pop_i && !rx_push_i && !srst_i)
        |=> ($stable(rx_rdata_o) && rx_lvl_o == 3'd0 && !sta_o[0]));

    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_i && !srst_i) |=> ($stable(tx_lvl_o) && $stable(tx_rdata_o) && $stable(sta_o[13])));

    assert_srst_clears_R8: assert property (@(posedge clk) disable iff (rst)
        srst_i |=> (tx_lvl_o == 3'd0 && rx_lvl_o == 3'd0 && !sta_o[13] && !sta_o[0]));

    assert_busy_only_on_srst_R9: assert property (@(posedge clk) disable iff (rst)
        !srst_i |=> $stable(sta_o[9]));

endmodule

bind sfifo_pair sfifo_pair_chk u_chk (
    .clk(clk), .rst(rst), .tx_en_i(tx_en_i), .rx_en_i(rx_en_i), .srst_i(srst_i),
    .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
    .tx_rdata_o(tx_rdata_o), .rx_rdata_o(rx_rdata_o),
    .tx_lvl_o(tx_lvl_o), .rx_lvl_o(rx_lvl_o), .sta_o(sta_o)
);

// File: tb/sfifo_pair_tb_top.sv
module sfifo_pair_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_en_i = 1'b0, rx_en_i = 1'b0, srst_i = 1'b0;
    logic        tx_push_i = 1'b0, tx_pop_i = 1'b0, rx_push_i = 1'b0, rx_pop_i = 1'b0;
    logic [8:0]  tx_wdata_i = '0, rx_wdata_i = '0;
    logic [8:0]  tx_rdata_o, rx_rdata_o;
    logic [2:0]  tx_lvl_o, rx_lvl_o;
    logic [15:0] sta_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sfifo_pair dut_i (
        .clk(clk), .rst(rst), .tx_en_i(tx_en_i), .rx_en_i(rx_en_i), .srst_i(srst_i),
        .tx_push_i(tx_push_i), .tx_wdata_i(tx_wdata_i), .tx_pop_i(tx_pop_i),
        .tx_rdata_o(tx_rdata_o), .rx_push_i(rx_push_i), .rx_wdata_i(rx_wdata_i),
        .rx_pop_i(rx_pop_i), .rx_rdata_o(rx_rdata_o), .tx_lvl_o(tx_lvl_o),
        .rx_lvl_o(rx_lvl_o), .sta_o(sta_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        tx_push_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_pop_i = 0; srst_i = 0;
    endtask

    function automatic logic [8:0] txv(input int i);
        return 9'(9'h101 + i * 37);
    endfunction

    function automatic logic [8:0] rxv(input int i);
        return 9'(9'h0F0 ^ (i * 19));
    endfunction

    task automatic t_reset();
        chk("R11 status", int'(sta_o), 0);
        chk("R11 tx level", int'(tx_lvl_o), 0);
        chk("R11 rx level", int'(rx_lvl_o), 0);
        chk("R11 rx data", int'(rx_rdata_o), 0);
        chk("R11 tx data", int'(tx_rdata_o), 0);
    endtask

    task automatic t_tx_fill_drain();
        for (int i = 0; i < 8; i++) begin
            tx_push_i = 1; tx_wdata_i = txv(i);
            tick();
            chk("R2 tx level", int'(tx_lvl_o), (i + 1) % 8);
            chk("R4 tx half", int'(sta_o[12]), int'(i + 1 >= 4));
            chk("R3 tx full", int'(sta_o[13]), int'(i + 1 == 8));
        end
        tx_wdata_i = 9'h1AA;
        tick();
        idle();
        chk("R5 tx full after extra push", int'(sta_o[13]), 1);
        chk("R5 tx level after extra push", int'(tx_lvl_o), 0);
        for (int i = 0; i < 8; i++) begin
            tx_pop_i = 1;
            tick();
            chk("R1 tx order", int'(tx_rdata_o), int'(txv(i)));
            chk("R2 tx level drain", int'(tx_lvl_o), 7 - i);
        end
        tx_pop_i = 0;
        tick();
        chk("R10 tx data held", int'(tx_rdata_o), int'(txv(7)));
        tx_pop_i = 1;
        tick();
        tx_pop_i = 0;
        chk("R6 tx pop empty data", int'(tx_rdata_o), int'(txv(7)));
        chk("R6 tx pop empty level", int'(tx_lvl_o), 0);
        chk("R6 tx pop empty not full", int'(sta_o[13]), 0);
    endtask

    task automatic t_rx_full_concurrent();
        for (int i = 0; i < 8; i++) begin
            rx_push_i = 1; rx_wdata_i = rxv(i);
            tick();
        end
        idle();
        chk("R3 rx full bit0", int'(sta_o[0]), 1);
        chk("R4 rx half bit14", int'(sta_o[14]), 1);
        chk("R2 rx level wraps", int'(rx_lvl_o), 0);
        chk("R3 tx full stays 0", int'(sta_o[13]), 0);
        rx_push_i = 1; rx_wdata_i = 9'h155; rx_pop_i = 1;
        tick();
        idle();
        chk("R5 concurrent pop data", int'(rx_rdata_o), int'(rxv(0)));
        chk("R5 concurrent level", int'(rx_lvl_o), 7);
        chk("R5 concurrent not full", int'(sta_o[0]), 0);
        for (int i = 1; i < 8; i++) begin
            rx_pop_i = 1;
            tick();
            chk("R1 rx order", int'(rx_rdata_o), int'(rxv(i)));
        end
        idle();
        chk("R5 discarded push absent", int'(rx_lvl_o), 0);
        chk("R4 rx half clear", int'(sta_o[14]), 0);
    endtask

    task automatic t_disable();
        rx_en_i = 0;
        rx_push_i = 1; rx_wdata_i = 9'h033;
        tick(); tick();
        idle();
        chk("R7 disabled push ignored", int'(rx_lvl_o), 0);
        rx_en_i = 1;
        rx_push_i = 1; rx_wdata_i = 9'h0A1; tick();
        rx_wdata_i = 9'h0A2; tick();
        idle();
        rx_en_i = 0;
        rx_pop_i = 1; tick();
        idle();
        chk("R7 disabled pop data", int'(rx_rdata_o), int'(rxv(7)));
        chk("R7 disabled pop level", int'(rx_lvl_o), 2);
        rx_en_i = 1;
        rx_pop_i = 1; tick();
        idle();
        chk("R7 kept word", int'(rx_rdata_o), 9'h0A1);
        chk("R7 level after enable", int'(rx_lvl_o), 1);
    endtask

    task automatic t_soft_reset();
        tx_push_i = 1; tx_wdata_i = 9'h0C3; tick(); tick();
        idle();
        srst_i = 1; rx_push_i = 1; tx_push_i = 1;
        tick();
        idle();
        chk("R8 rx emptied", int'(rx_lvl_o), 0);
        chk("R8 tx emptied", int'(tx_lvl_o), 0);
        chk("R9 busy set with rx data", int'(sta_o[9]), 1);
        tick();
        chk("R8 push during srst dropped", int'(rx_lvl_o), 0);
        chk("R9 busy holds", int'(sta_o[9]), 1);
        tx_push_i = 1; tx_wdata_i = 9'h011; tick();
        idle();
        srst_i = 1; tick(); tick();
        idle();
        chk("R9 busy cleared rx empty", int'(sta_o[9]), 0);
        chk("R8 tx cleared", int'(tx_lvl_o), 0);
        rx_push_i = 1; rx_wdata_i = 9'h077; tick();
        rx_push_i = 0; srst_i = 1; tick();
        srst_i = 1; tick();
        idle();
        chk("R9 only first srst cycle counts", int'(sta_o[9]), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 0;
        tick();
        t_reset();
        tx_en_i = 1; rx_en_i = 1;
        t_tx_fill_drain();
        t_rx_full_concurrent();
        t_disable();
        t_soft_reset();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule